// File: doc/BRIEF.md
# Instruction Address Sequencer

This block produces the fetch address for a small microcontroller core. It keeps a 13-bit program counter, a 5-bit page holding register that software loads ahead of a branch, and an 8-level hardware return stack. Each cycle the decoder hands it one operation code, an 11-bit branch literal and a byte of write data. An interrupt request takes precedence over that operation.

The upper program counter bits cannot be written directly. They are copied from the holding register only when a branch or a write to the low counter byte takes effect. A parameter sets how many address bits the program memory actually decodes. The fetch address is folded onto that smaller memory, so code above the implemented size aliases back to the bottom.

Top module: `fetch_addr_unit`

## Requirements
- R1: While rst_ni is low, and after it is released, the counter and holding register read 0 and the fetch address is 0000h.
- R2: op_i code 1 advances the counter by one, and 1FFFh rolls over to 0000h. Codes 0, 6 and 7 leave the counter unchanged.
- R3: op_i code 2 (branch) loads counter bits 10:0 from lit_i and counter bits 12:11 from holding register bits 4:3. Holding bits 2:0 have no effect on the result.
- R4: op_i code 3 (subroutine call) loads the counter the same way as a branch and pushes the counter value plus one onto the return stack.
- R5: op_i code 4 (return) loads the counter from the top of the return stack, removes that entry, and leaves the holding register unchanged.
- R6: op_i code 5 (low byte write) loads counter bits 7:0 from pcl_d_i and counter bits 12:8 from the whole holding register.
- R7: hold_we_i loads hold_d_i into the holding register at the clock edge and by itself does not change the counter. A branch in the same cycle uses the old holding value.
- R8: irq_i loads the counter with 0004h and pushes the current counter value, whatever op_i holds.
- R9: The return stack has 8 entries, is last-in first-out and wraps. A ninth push overwrites the oldest entry, and there is no overflow or underflow indication.
- R10: fetch_addr_o is the counter masked to its low ADDR_W bits. pcl_o is always counter bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 1 | Interrupt entry request |
| op_i | input | 3 | Operation code: 0 idle, 1 increment, 2 branch, 3 call, 4 return, 5 low byte write |
| lit_i | input | 11 | Branch or call target literal |
| pcl_d_i | input | 8 | Data for a low byte write |
| hold_we_i | input | 1 | Holding register write enable |
| hold_d_i | input | 5 | Holding register write data |
| fetch_addr_o | output | 13 | Fetch address, folded to ADDR_W bits |
| pcl_o | output | 8 | Low counter byte for reads |
| hold_o | output | 5 | Holding register value |

## Verification
The bench drives two instances in parallel, one with the full 8K space and one folded to 4K. A design that ignored the fold would present addresses above 0FFFh to the smaller memory. Branches are issued with a holding value whose low three bits are set, and with a holding write in the same cycle. A design that took the page from the wrong bits, or from the freshly written value, would land in the wrong 2K page. Nine nested calls followed by nine returns check the wrapping stack: a ninth return that does not reproduce the newest address shows a saturating or mis-indexed pointer. An interrupt arriving alongside a branch shows whether the vector wins and whether the preempted address is the one saved.

// File: rtl/fau_pkg.sv
package fau_pkg;
  typedef enum logic [2:0] {
    OP_IDLE = 3'd0,
    OP_INC  = 3'd1,
    OP_GOTO = 3'd2,
    OP_CALL = 3'd3,
    OP_RET  = 3'd4,
    OP_PCL  = 3'd5
  } op_e;
endpackage

// File: rtl/fau_hold_reg.sv
module fau_hold_reg #(
  parameter int W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= d_i;
  end

  assert_hold_stable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(q_o));
endmodule

// File: rtl/fau_ret_stack.sv
module fau_ret_stack #(
  parameter int DEPTH = 8,
  parameter int W     = 13
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] top_o
);
  localparam int PW = $clog2(DEPTH);

  logic [PW-1:0] ptr_q;
  logic [PW-1:0] ptr_dec;
  logic [W-1:0]  mem_q [DEPTH];

  assign ptr_dec = ptr_q - PW'(1);
  assign top_o   = mem_q[ptr_dec];

  // circular pointer: overflow silently overwrites the oldest slot
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (push_i) begin
      mem_q[ptr_q] <= d_i;
      ptr_q        <= ptr_q + PW'(1);
    end else if (pop_i) begin
      ptr_q <= ptr_dec;
    end
  end

  assert_push_adv_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> ptr_q == $past(ptr_q) + PW'(1));
  assert_pop_back_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i) |=> ptr_q == $past(ptr_q) - PW'(1));
  assert_push_top_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> top_o == $past(d_i));
endmodule

// File: rtl/fetch_addr_unit.sv
module fetch_addr_unit
  import fau_pkg::*;
#(
  parameter int PC_W   = 13,
  parameter int LIT_W  = 11,
  parameter int HOLD_W = 5,
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              irq_i,
  input  logic [2:0]        op_i,
  input  logic [LIT_W-1:0]  lit_i,
  input  logic [7:0]        pcl_d_i,
  input  logic              hold_we_i,
  input  logic [HOLD_W-1:0] hold_d_i,
  output logic [PC_W-1:0]   fetch_addr_o,
  output logic [7:0]        pcl_o,
  output logic [HOLD_W-1:0] hold_o
);
  localparam int            PAGE_W = PC_W - LIT_W;
  localparam logic [PC_W-1:0] IRQ_VEC = PC_W'(4);
  localparam logic [PC_W-1:0] MASK    = PC_W'((64'd1 << ADDR_W) - 64'd1);

  logic [PC_W-1:0]   pc_q, pc_d, pc_inc, push_d, stk_top;
  logic [HOLD_W-1:0] hold_q;
  logic              push, pop;
  op_e               op;

  assign op     = op_e'(op_i);
  assign pc_inc = pc_q + PC_W'(1);

  fau_hold_reg #(.W(HOLD_W)) u_hold (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (hold_we_i),
    .d_i   (hold_d_i),
    .q_o   (hold_q)
  );

  fau_ret_stack #(.DEPTH(DEPTH), .W(PC_W)) u_stack (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .push_i(push),
    .pop_i (pop),
    .d_i   (push_d),
    .top_o (stk_top)
  );

  always_comb begin
    pc_d   = pc_q;
    push   = 1'b0;
    pop    = 1'b0;
    push_d = pc_inc;
    if (irq_i) begin
      pc_d   = IRQ_VEC;
      push   = 1'b1;
      push_d = pc_q;
    end else begin
      unique case (op)
        OP_INC:  pc_d = pc_inc;
        OP_GOTO: pc_d = {hold_q[HOLD_W-1 -: PAGE_W], lit_i};
        OP_CALL: begin
          pc_d = {hold_q[HOLD_W-1 -: PAGE_W], lit_i};
          push = 1'b1;
        end
        OP_RET: begin
          pc_d = stk_top;
          pop  = 1'b1;
        end
        OP_PCL:  pc_d = {hold_q, pcl_d_i};
        default: pc_d = pc_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_d;
  end

  assign fetch_addr_o = pc_q & MASK;
  assign pcl_o        = pc_q[7:0];
  assign hold_o       = hold_q;

  assert_irq_vec_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |=> pc_q == IRQ_VEC);
  assert_inc_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_i && op_i == 3'd1) |=> pc_q == $past(pc_q) + PC_W'(1));
  assert_branch_page_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_i && (op_i == 3'd2 || op_i == 3'd3)) |=>
      (pc_q[LIT_W-1:0] == $past(lit_i)) &&
      (pc_q[PC_W-1:LIT_W] == $past(hold_o[HOLD_W-1 -: PAGE_W])));
  assert_pcl_upper_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_i && op_i == 3'd5) |=> pc_q == {$past(hold_o), $past(pcl_d_i)});
  assert_ret_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_i && op_i == 3'd4 && !hold_we_i) |=> $stable(hold_o));
endmodule

// File: tb/fetch_addr_unit_bench.sv
`timescale 1ns/1ps
module fetch_addr_unit_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        irq = 0;
  logic [2:0]  op = 0;
  logic [10:0] lit = 0;
  logic [7:0]  dat = 0;
  logic        hwe = 0;
  logic [4:0]  hd = 0;
  logic [12:0] fa, fa_s;
  logic [7:0]  pcl, pcl_s;
  logic [4:0]  hold, hold_s;
  int n_chk = 0, n_bad = 0, cyc = 0;

  always #4 clk = ~clk;

  fetch_addr_unit u_fetch_addr_unit (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .op_i(op), .lit_i(lit),
    .pcl_d_i(dat), .hold_we_i(hwe), .hold_d_i(hd),
    .fetch_addr_o(fa), .pcl_o(pcl), .hold_o(hold));

  fetch_addr_unit #(.ADDR_W(12)) u_small (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .op_i(op), .lit_i(lit),
    .pcl_d_i(dat), .hold_we_i(hwe), .hold_d_i(hd),
    .fetch_addr_o(fa_s), .pcl_o(pcl_s), .hold_o(hold_s));

  // {op, irq, lit, data, hold_we, hold_d, expected pc}
  localparam logic [41:0] VEC [17] = '{
    {3'd1, 1'b0, 11'h000, 8'h00, 1'b0, 5'h00, 13'h0001}, // R2
    {3'd1, 1'b0, 11'h000, 8'h00, 1'b0, 5'h00, 13'h0002}, // R2
    {3'd0, 1'b0, 11'h000, 8'h00, 1'b1, 5'h16, 13'h0002}, // R7
    {3'd2, 1'b0, 11'h123, 8'h00, 1'b0, 5'h00, 13'h1123}, // R3
    {3'd1, 1'b0, 11'h000, 8'h00, 1'b0, 5'h00, 13'h1124}, // R2
    {3'd3, 1'b0, 11'h7FF, 8'h00, 1'b0, 5'h00, 13'h17FF}, // R4
    {3'd1, 1'b0, 11'h000, 8'h00, 1'b0, 5'h00, 13'h1800}, // R2
    {3'd5, 1'b0, 11'h000, 8'h5A, 1'b0, 5'h00, 13'h165A}, // R6
    {3'd4, 1'b0, 11'h000, 8'h00, 1'b0, 5'h00, 13'h1125}, // R5
    {3'd2, 1'b1, 11'h000, 8'h00, 1'b0, 5'h00, 13'h0004}, // R8
    {3'd1, 1'b0, 11'h000, 8'h00, 1'b0, 5'h00, 13'h0005}, // R2
    {3'd4, 1'b0, 11'h000, 8'h00, 1'b0, 5'h00, 13'h1125}, // R8
    {3'd2, 1'b0, 11'h010, 8'h00, 1'b1, 5'h03, 13'h1010}, // R7
    {3'd2, 1'b0, 11'h00F, 8'h00, 1'b0, 5'h00, 13'h000F}, // R3
    {3'd6, 1'b0, 11'h000, 8'h00, 1'b0, 5'h00, 13'h000F}, // R2
    {3'd5, 1'b0, 11'h000, 8'hFF, 1'b0, 5'h00, 13'h03FF}, // R6
    {3'd1, 1'b0, 11'h000, 8'h00, 1'b0, 5'h00, 13'h0400}  // R2
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic chk_pc(input string tag, input logic [12:0] exp);
    chk({tag, " fetch"}, 32'(fa), 32'(exp));
    chk({tag, " R10 folded"}, 32'(fa_s), 32'(exp & 13'h0FFF));
    chk({tag, " R10 low byte"}, 32'(pcl), 32'(exp[7:0]));
  endtask

  task automatic step(input logic [2:0] o, input logic i, input logic [10:0] l,
                      input logic [7:0] d, input logic w, input logic [4:0] h);
    @(negedge clk);
    op = o; irq = i; lit = l; dat = d; hwe = w; hd = h;
    @(posedge clk);
    #1;
    op = 0; irq = 0; hwe = 0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: got hang expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    #20;
    chk_pc("R1 in reset", 13'h0000);
    chk("R1 hold in reset", 32'(hold), 0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk_pc("R1 after release", 13'h0000);

    for (int k = 0; k < 17; k++) begin
      logic [41:0] v;
      v = VEC[k];
      step(v[41:39], v[38], v[37:27], v[26:19], v[18], v[17:13]);
      chk_pc($sformatf("vec %0d", k), v[12:0]);
    end
    chk("R7 hold value", 32'(hold), 32'h03);
    chk("R10 folded hold", 32'(hold_s), 32'h03);

    // R2 rollover at top of space
    step(3'd0, 1'b0, 11'h0, 8'h00, 1'b1, 5'h1F);
    step(3'd5, 1'b0, 11'h0, 8'hFF, 1'b0, 5'h00);
    chk_pc("R6 top", 13'h1FFF);
    step(3'd1, 1'b0, 11'h0, 8'h00, 1'b0, 5'h00);
    chk_pc("R2 rollover", 13'h0000);

    // R9 nine nested calls, then nine returns
    step(3'd0, 1'b0, 11'h0, 8'h00, 1'b1, 5'h00);
    for (int k = 0; k < 9; k++) begin
      step(3'd5, 1'b0, 11'h0, 8'(2 * k), 1'b0, 5'h00);
      step(3'd3, 1'b0, 11'h100, 8'h00, 1'b0, 5'h00);
    end
    chk_pc("R4 call target", 13'h0100);
    for (int k = 8; k >= 1; k--) begin
      step(3'd4, 1'b0, 11'h0, 8'h00, 1'b0, 5'h00);
      chk_pc($sformatf("R9 pop %0d", k), 13'(2 * k + 1));
    end
    step(3'd4, 1'b0, 11'h0, 8'h00, 1'b0, 5'h00);
    chk_pc("R9 ninth pop wraps", 13'h0011);

    // R1 asynchronous reset mid-run
    step(3'd0, 1'b0, 11'h0, 8'h00, 1'b1, 5'h1A);
    @(negedge clk); rst_n = 0;
    #1;
    chk_pc("R1 mid-run reset", 13'h0000);
    chk("R1 mid-run hold", 32'(hold), 0);
    @(negedge clk); rst_n = 1;
    step(3'd4, 1'b0, 11'h0, 8'h00, 1'b0, 5'h00);
    chk_pc("R9 stack cleared", 13'h0000);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule